// File: doc/BRIEF.md
# SONET/SDH Receive Byte Aligner and Framer

This block sits behind clock and data recovery in a SONET/SDH receiver. It takes the recovered bit stream, one bit per rising edge of the bit clock, and turns it into bytes. It finds where the bytes start by looking for the section framing sequence, which is three A1 bytes (8'hF6) followed by three A2 bytes (8'h28). The aligned bytes come out on an 8-bit bus together with a byte clock equal to the bit clock divided by eight.

The byte boundary is sticky. A search for a new boundary starts only when the out-of-frame input rises. While a search is open, the first complete framing sequence seen at any bit offset fixes the boundary, and the byte divider is re-phased to match it. After that the boundary stays put, even if framing bytes show up at some other offset. This lasts until the next out-of-frame rising edge. A separate disable input holds off any commit. A one-byte sync pulse marks every framing sequence that lands on the current byte boundaries, whatever the level of the out-of-frame input.

Top module: `sonet_byte_aligner`

## Requirements
- R1: While rst_ni is low and after its release, byte_o is 8'h00, sync_o is 0 and byte_clk_o is 0, and no search is open.
- R2: byte_clk_o is low for four bit clocks and then high for four. byte_o and sync_o change only on the bit clock edge where byte_clk_o falls.
- R3: Bits arrive most significant first. byte_o[7] carries the earliest received bit of each byte and byte_o[0] the latest.
- R4: With no rising edge on oof_i since reset, a framing sequence that lies off the current byte boundaries does not move the boundary and raises no sync pulse.
- R5: While a search is open, a full sequence of three 8'hF6 bytes followed by three 8'h28 bytes, ending at any bit offset, is committed on the next bit clock edge. On that edge byte_clk_o falls, byte_o becomes 8'h28 and sync_o goes high. The next byte starts with the bit that follows the last A2 bit.
- R6: Each time the aligned output completes the framing sequence, sync_o is high for exactly eight bit clocks (one byte clock period). This happens whether oof_i is high or low.
- R7: Once committed, the boundary is kept when the framing sequence appears at any other bit offset. No sync pulse is raised for it.
- R8: While realign_dis_i is high, no commit takes place. An open search stays open and commits on the first sequence seen after realign_dis_i falls.
- R9: A rising edge of oof_i after a commit opens a new search, and the next sequence found moves the boundary to its offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Serial receive data, MSB of each byte first |
| oof_i | input | 1 | Out-of-frame indication; a rising edge opens a search |
| realign_dis_i | input | 1 | Holds off any boundary commit while high |
| byte_o | output | 8 | Aligned byte, bit 0 least significant |
| byte_clk_o | output | 1 | Byte clock, bit clock divided by eight |
| sync_o | output | 1 | One byte clock wide framing pulse |

## Verification
The hardest case to reach from the ports is a framing sequence that turns up at a wrong bit offset after the boundary is already committed. The design must ignore it without any visible change. The stimulus covers this in each vector. It first locks at a random start offset. Then it sends a full false A1/A2 sequence shifted by one to seven bits, followed by enough padding to bring the stream back onto a byte multiple. Next it checks that two known bytes still come out intact on the old boundaries and that no sync pulse appeared. Finally a true aligned sequence is sent, with oof_i either held high or low, and it must raise the pulse.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int unsigned SBA_BYTE_W  = 8;
  localparam int unsigned SBA_RUN_LEN = 3;
  localparam logic [7:0]  SBA_A1      = 8'hF6;
  localparam logic [7:0]  SBA_A2      = 8'h28;

  typedef enum logic {
    HUNT_IDLE = 1'b0,
    HUNT_OPEN = 1'b1
  } hunt_e;
endpackage

// File: rtl/sba_window.sv
module sba_window
  import sba_pkg::*;
#(
  parameter int unsigned BYTE_W  = SBA_BYTE_W,
  parameter int unsigned RUN_LEN = SBA_RUN_LEN,
  parameter logic [BYTE_W-1:0] A1_BYTE = SBA_A1,
  parameter logic [BYTE_W-1:0] A2_BYTE = SBA_A2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] win_o,
  output logic              match_o
);
  localparam int unsigned N_BYTES = 2 * RUN_LEN;
  localparam int unsigned WIN_W   = N_BYTES * BYTE_W;

  logic [WIN_W-1:0] sr_q;
  logic [WIN_W-1:0] pat;

  // byte 0 = newest (last A2), top bytes = oldest (first A1)
  for (genvar g = 0; g < N_BYTES; g++) begin : g_pat
    if (g < RUN_LEN) begin : g_a2
      assign pat[g*BYTE_W +: BYTE_W] = A2_BYTE;
    end else begin : g_a1
      assign pat[g*BYTE_W +: BYTE_W] = A1_BYTE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[WIN_W-2:0], bit_i};
  end

  assign win_o   = sr_q[BYTE_W-1:0];
  assign match_o = (sr_q == pat);
endmodule

// File: rtl/sba_hunt.sv
module sba_hunt
  import sba_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oof_i,
  input  logic dis_i,
  input  logic match_i,
  output logic hunting_o,
  output logic commit_o
);
  logic  oof_q;
  hunt_e st_q, st_d;
  logic  oof_rise;

  assign oof_rise = oof_i & ~oof_q;
  assign commit_o = (st_q == HUNT_OPEN) & match_i & ~dis_i;

  always_comb begin
    st_d = st_q;
    if (oof_rise)      st_d = HUNT_OPEN;
    else if (commit_o) st_d = HUNT_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oof_q <= 1'b0;
      st_q  <= HUNT_IDLE;
    end else begin
      oof_q <= oof_i;
      st_q  <= st_d;
    end
  end

  assign hunting_o = (st_q == HUNT_OPEN);

  // R9
  hunt_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oof_i && !oof_q) |=> hunting_o);

  // R4
  hunt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hunting_o && !(oof_i && !oof_q)) |=> !hunting_o);

  // R7
  hunt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hunting_o && !match_i) |=> hunting_o);
endmodule

// File: rtl/sba_divider.sv
module sba_divider
  import sba_pkg::*;
#(
  parameter int unsigned BYTE_W  = SBA_BYTE_W,
  parameter logic [BYTE_W-1:0] A2_BYTE = SBA_A2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              match_i,
  input  logic [BYTE_W-1:0] win_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_clk_o,
  output logic              sync_o
);
  localparam int unsigned PH_W = $clog2(BYTE_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_W - 1);

  logic [PH_W-1:0]   ph_q;
  logic [BYTE_W-1:0] byte_q;
  logic              sync_q;
  logic              bnd;

  // commit re-phases the divider onto the found boundary
  assign bnd = commit_i | (ph_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      byte_q <= '0;
      sync_q <= 1'b0;
    end else begin
      ph_q <= commit_i ? '0 : ph_q + 1'b1;
      if (bnd) begin
        byte_q <= win_i;
        sync_q <= match_i;
      end
    end
  end

  assign byte_o     = byte_q;
  assign sync_o     = sync_q;
  assign byte_clk_o = ph_q[PH_W-1];

  // R2
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> $stable(byte_q));

  // R6
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> $stable(sync_q));

  // R5
  commit_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (ph_q == '0) && sync_q && !byte_clk_o);

  // R6
  sync_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |-> (byte_q == A2_BYTE));
endmodule

// File: rtl/sonet_byte_aligner.sv
module sonet_byte_aligner
  import sba_pkg::*;
#(
  parameter int unsigned BYTE_W  = SBA_BYTE_W,
  parameter int unsigned RUN_LEN = SBA_RUN_LEN,
  parameter logic [BYTE_W-1:0] A1_BYTE = SBA_A1,
  parameter logic [BYTE_W-1:0] A2_BYTE = SBA_A2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_bit_i,
  input  logic              oof_i,
  input  logic              realign_dis_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_clk_o,
  output logic              sync_o
);
  logic [BYTE_W-1:0] win;
  logic              match;
  logic              hunting;
  logic              commit;

  sba_window #(
    .BYTE_W (BYTE_W),
    .RUN_LEN(RUN_LEN),
    .A1_BYTE(A1_BYTE),
    .A2_BYTE(A2_BYTE)
  ) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (rx_bit_i),
    .win_o  (win),
    .match_o(match)
  );

  sba_hunt u_hunt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .oof_i    (oof_i),
    .dis_i    (realign_dis_i),
    .match_i  (match),
    .hunting_o(hunting),
    .commit_o (commit)
  );

  sba_divider #(
    .BYTE_W (BYTE_W),
    .A2_BYTE(A2_BYTE)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .match_i   (match),
    .win_i     (win),
    .byte_o    (byte_o),
    .byte_clk_o(byte_clk_o),
    .sync_o    (sync_o)
  );

  // R8
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (realign_dis_i && hunting) |=> hunting);
endmodule

// File: tb/sonet_byte_aligner_bench.sv
module sonet_byte_aligner_bench;
  localparam logic [7:0] A1 = 8'hF6;
  localparam logic [7:0] A2 = 8'h28;
  // {hold_oof[12], start_offset[11:8], payload[7:0]}
  localparam logic [15:0] VEC [6] = '{16'h005A, 16'h13C3, 16'h050F,
                                      16'h1791, 16'h027E, 16'h161D};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_bit_i = 1'b0;
  logic       oof_i = 1'b0;
  logic       realign_dis_i = 1'b0;
  logic [7:0] byte_o;
  logic       byte_clk_o;
  logic       sync_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sonet_byte_aligner u_sonet_byte_aligner (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .rx_bit_i     (rx_bit_i),
    .oof_i        (oof_i),
    .realign_dis_i(realign_dis_i),
    .byte_o       (byte_o),
    .byte_clk_o   (byte_clk_o),
    .sync_o       (sync_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_bit_i = b;
    @(posedge clk);
    #1;
  endtask

  task automatic send_zeros(input int n, input bit chk_sync, input string req);
    for (int i = 0; i < n; i++) begin
      send_bit(1'b0);
      if (chk_sync) check(sync_o == 1'b0, req, 8'(sync_o), 8'h00);
    end
  endtask

  task automatic send_pattern(input bit chk_sync, input string req);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v;
      v = (k < 3) ? A1 : A2;
      for (int i = 7; i >= 0; i--) begin
        send_bit(v[i]);
        if (chk_sync) check(sync_o == 1'b0, req, 8'(sync_o), 8'h00);
      end
    end
  endtask

  // one byte on the committed boundary; checks phase, previous byte, sync
  task automatic byte_step(input logic [7:0] v, input bit chk_prev,
                           input logic [7:0] prev, input logic exp_sync);
    for (int i = 7; i >= 0; i--) begin
      int ph;
      ph = 7 - i;
      send_bit(v[i]);
      check(byte_clk_o == (ph >= 4), "R2", 8'(byte_clk_o), 8'(ph >= 4));
      if (chk_prev) check(byte_o == prev, "R3", byte_o, prev);
      check(sync_o == exp_sync, "R6", 8'(sync_o), 8'(exp_sync));
    end
  endtask

  task automatic do_reset;
    rst_ni = 1'b0;
    oof_i = 1'b0;
    realign_dis_i = 1'b0;
    rx_bit_i = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_ni = 1'b1;
  endtask

  initial begin
    #1;
    do_reset;
    // R1 reset state
    check(byte_o == 8'h00, "R1", byte_o, 8'h00);
    check(sync_o == 1'b0, "R1", 8'(sync_o), 8'h00);
    check(byte_clk_o == 1'b0, "R1", 8'(byte_clk_o), 8'h00);

    // main vectors: random start offset, false pattern, aligned pattern
    for (int v = 0; v < 6; v++) begin
      logic       hold;
      int         off;
      int         s;
      logic [7:0] p0, p1, p2;
      hold = VEC[v][12];
      off  = int'(VEC[v][11:8]);
      p0   = VEC[v][7:0];
      p1   = ~p0;
      p2   = p0 ^ 8'h66;
      s    = (off % 7) + 1;
      do_reset;
      oof_i = 1'b1;
      send_zeros(16 + off, 1'b0, "R5");
      if (!hold) oof_i = 1'b0;
      send_pattern(1'b0, "R5");
      check(sync_o == 1'b0, "R5", 8'(sync_o), 8'h00);
      byte_step(p0, 1'b1, A2, 1'b1);  // R5 commit
      byte_step(p1, 1'b1, p0, 1'b0);  // R3
      byte_step(p2, 1'b1, p1, 1'b0);
      // R7 false pattern shifted by s bits
      send_zeros(s, 1'b1, "R7");
      send_pattern(1'b1, "R7");
      send_zeros(8 - s, 1'b1, "R7");
      byte_step(8'h3C, 1'b0, 8'h00, 1'b0);
      byte_step(8'hA5, 1'b1, 8'h3C, 1'b0);  // R7 boundary kept
      // R6 aligned pattern, oof level per vector
      byte_step(A1, 1'b1, 8'hA5, 1'b0);
      byte_step(A1, 1'b1, A1, 1'b0);
      byte_step(A1, 1'b1, A1, 1'b0);
      byte_step(A2, 1'b1, A1, 1'b0);
      byte_step(A2, 1'b1, A2, 1'b0);
      byte_step(A2, 1'b1, A2, 1'b0);
      byte_step(8'h00, 1'b1, A2, 1'b1);  // R6 pulse
      byte_step(8'h00, 1'b1, 8'h00, 1'b0);
      oof_i = 1'b0;
    end

    // R4 no search without oof edge; reset boundary after 7 bits
    do_reset;
    send_zeros(7, 1'b1, "R4");
    send_zeros(3, 1'b1, "R4");
    send_pattern(1'b1, "R4");
    send_zeros(5, 1'b1, "R4");
    byte_step(8'h3C, 1'b0, 8'h00, 1'b0);
    byte_step(8'h81, 1'b1, 8'h3C, 1'b0);  // R4 boundary unchanged

    // R8 disable blocks commit, search stays open
    do_reset;
    oof_i = 1'b1;
    send_zeros(2, 1'b0, "R8");
    oof_i = 1'b0;
    realign_dis_i = 1'b1;
    send_zeros(16, 1'b1, "R8");
    send_pattern(1'b1, "R8");
    send_zeros(8, 1'b1, "R8");
    realign_dis_i = 1'b0;
    send_zeros(3, 1'b0, "R8");
    send_pattern(1'b0, "R8");
    byte_step(8'h42, 1'b1, A2, 1'b1);  // R8 commit after release
    byte_step(8'h00, 1'b1, 8'h42, 1'b0);

    // R9 new oof edge moves boundary
    do_reset;
    oof_i = 1'b1;
    send_zeros(5, 1'b0, "R9");
    send_pattern(1'b0, "R9");
    oof_i = 1'b0;
    byte_step(8'h11, 1'b1, A2, 1'b1);
    oof_i = 1'b1;
    send_zeros(3, 1'b0, "R9");
    oof_i = 1'b0;
    send_pattern(1'b0, "R9");
    byte_step(8'h22, 1'b1, A2, 1'b1);  // R9 new offset committed
    byte_step(8'h00, 1'b1, 8'h22, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule